// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block supervises software with a 16-bit free-running counter and one compare channel. The upper byte of the counter is checked against a compare byte. A second byte holds an offset. Software keeps the system alive by writing any value to the kick register. While the watchdog is armed, each kick reloads the compare byte with the current counter upper byte plus that offset, so the deadline keeps moving ahead of the counter. When the counter low byte wraps while the upper byte still equals the compare byte, the block emits a one-cycle reset pulse. The timeout in counter ticks is therefore 256 × offset + (256 − low byte at the kick).

The watchdog comes out of reset armed with a zero compare byte and a zero offset. It therefore fires after the first 256 ticks unless software disarms it. While armed, the counter is forced to run, and several registers are locked against writes. A single-cycle `tick` input stands in for the selected counter clock source. Software uses a simple write port and a combinational read port with a 3-bit address.

Top module: `cmp_watchdog`

## Requirements
- R1: After reset, CTRL (address 0) reads 0x80 with arm = bit 7 set, and the counter, offset (address 4) and compare byte (address 5) read 0. With no writes, the first reset pulse follows the 256th tick.
- R2: While disarmed, the counter advances by one on each `tick` only if run (CTRL bit 0) is set. Writes to counter low (address 1) and counter high (address 2) take effect and win over a same-cycle tick.
- R3: When a tick wraps the counter low byte from 0xFF while armed and the counter high byte equals the compare byte, `wdt_rst` is high for exactly the next cycle. The timeout is 256 × offset + (256 − low byte at the kick) ticks.
- R4: A write of any value to address 5 while armed loads the compare byte with (counter high + offset) mod 256. While disarmed, the same write stores the written value.
- R5: Writes to the offset register at address 4 take effect only while disarmed.
- R6: While armed, writes to addresses 1 and 2 are ignored.
- R7: While armed, the counter advances on every tick whatever run holds. Run is still stored from each CTRL write and reads back as last written, so it reads 0 if software never set it.
- R8: While armed, idle-hold (CTRL bit 1) and clock-select (CTRL bits 4:2) are frozen and ignore CTRL writes.
- R9: While armed, writes to the mode register (address 3) are ignored and it reads as the software-timer code 0x48. While disarmed, it reads back the stored value.
- R10: A reset pulse leaves arm set. A CTRL write that clears arm in the same cycle as a firing wrap loses to the firing.
- R11: No reset pulse is produced while disarmed, even when the counter high byte equals the compare byte at a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle counter clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
A register write takes effect at the rising edge that samples `wr_en`. Its result can therefore be read back on `rd_data` in the following cycle, because the read path adds no register. The reset pulse is registered: it is high for the one cycle after the edge that performs the firing wrap. The bench drives every input on the falling edge and samples on a later falling edge. After each tick it looks at `wdt_rst` at the next falling edge, so the number of the tick that fired can be compared with the timeout formula.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

   typedef enum logic [2:0] {
      A_CTRL = 3'd0,
      A_CNTL = 3'd1,
      A_CNTH = 3'd2,
      A_MODE = 3'd3,
      A_OFFS = 3'd4,
      A_KICK = 3'd5
   } wdc_addr_e;

   localparam int CTL_RUN     = 0;
   localparam int CTL_IDLE    = 1;
   localparam int CTL_SEL_LSB = 2;
   localparam int CTL_SEL_W   = 3;

endpackage

// File: rtl/wdc_counter.sv
module wdc_counter #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic          lock,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cnt_lo,
   output logic [DW-1:0] cnt_hi,
   output logic          wrap
);
   localparam int CW = 2 * DW;

   logic step;
   assign step = run & tick;
   assign wrap = step & (&cnt_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         if (step)
            {cnt_hi, cnt_lo} <= {cnt_hi, cnt_lo} + CW'(1);
         if (wr_lo && !lock)
            cnt_lo <= wdata;
         if (wr_hi && !lock)
            cnt_hi <= wdata;
      end
   end
endmodule

// File: rtl/wdc_compare.sv
module wdc_compare #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          armed,
   input  logic          wrap,
   input  logic [DW-1:0] cnt_hi,
   input  logic          wr_off,
   input  logic          wr_kick,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cmp_hi,
   output logic [DW-1:0] offset,
   output logic          hit
);
   logic [DW-1:0] reload;

   assign reload = cnt_hi + offset;
   assign hit    = armed & wrap & (cnt_hi == cmp_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_hi <= '0;
         offset <= '0;
      end else begin
         if (wr_off && !armed)
            offset <= wdata;
         if (wr_kick)
            cmp_hi <= armed ? reload : wdata;
      end
   end
endmodule

// File: rtl/wdc_ctrl.sv
module wdc_ctrl
   import wdc_pkg::*;
#(
   parameter int          DW       = 8,
   parameter logic [DW-1:0] SWT_MODE = 8'h48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hit,
   input  logic                 wr_ctl,
   input  logic                 wr_mode,
   input  logic [DW-1:0]        wdata,
   output logic                 armed,
   output logic                 run_sw,
   output logic                 idle,
   output logic [CTL_SEL_W-1:0] clk_sel,
   output logic [DW-1:0]        mode_rd
);
   logic [DW-1:0] mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b1;
         run_sw  <= 1'b0;
         idle    <= 1'b0;
         clk_sel <= '0;
         mode_q  <= '0;
      end else begin
         if (hit)
            armed <= 1'b1;
         else if (wr_ctl)
            armed <= wdata[DW-1];
         if (wr_ctl)
            run_sw <= wdata[CTL_RUN];
         if (wr_ctl && !armed) begin
            idle    <= wdata[CTL_IDLE];
            clk_sel <= wdata[CTL_SEL_LSB +: CTL_SEL_W];
         end
         if (wr_mode && !armed)
            mode_q <= wdata;
      end
   end

   assign mode_rd = armed ? SWT_MODE : mode_q;
endmodule

// File: rtl/cmp_watchdog.sv
module cmp_watchdog
   import wdc_pkg::*;
#(
   parameter int            DW        = 8,
   parameter int            AW        = 3,
   parameter logic [DW-1:0] SWT_MODE  = 8'h48,
   parameter bit            SYNC_READ = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          wdt_rst
);
   if (DW < 8 || DW > 16) begin : g_bad_dw
      $error("cmp_watchdog: DW must lie in 8..16");
   end
   if (AW < 3) begin : g_bad_aw
      $error("cmp_watchdog: AW must be at least 3");
   end

   logic                 armed, run_sw, idle, wrap, hit, fire_q;
   logic [CTL_SEL_W-1:0] clk_sel;
   logic [DW-1:0]        cnt_lo, cnt_hi, cmp_hi, offset, mode_rd, ctrl_rd, rd_mux;
   logic                 wr_ctl, wr_cntl, wr_cnth, wr_mode, wr_offs, wr_kick;

   assign wr_ctl  = wr_en && (wr_addr == AW'(A_CTRL));
   assign wr_cntl = wr_en && (wr_addr == AW'(A_CNTL));
   assign wr_cnth = wr_en && (wr_addr == AW'(A_CNTH));
   assign wr_mode = wr_en && (wr_addr == AW'(A_MODE));
   assign wr_offs = wr_en && (wr_addr == AW'(A_OFFS));
   assign wr_kick = wr_en && (wr_addr == AW'(A_KICK));

   wdc_ctrl #(.DW(DW), .SWT_MODE(SWT_MODE)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .wr_ctl  (wr_ctl),
      .wr_mode (wr_mode),
      .wdata   (wr_data),
      .armed   (armed),
      .run_sw  (run_sw),
      .idle    (idle),
      .clk_sel (clk_sel),
      .mode_rd (mode_rd)
   );

   wdc_counter #(.DW(DW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .run    (run_sw | armed),
      .lock   (armed),
      .wr_lo  (wr_cntl),
      .wr_hi  (wr_cnth),
      .wdata  (wr_data),
      .cnt_lo (cnt_lo),
      .cnt_hi (cnt_hi),
      .wrap   (wrap)
   );

   wdc_compare #(.DW(DW)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (armed),
      .wrap    (wrap),
      .cnt_hi  (cnt_hi),
      .wr_off  (wr_offs),
      .wr_kick (wr_kick),
      .wdata   (wr_data),
      .cmp_hi  (cmp_hi),
      .offset  (offset),
      .hit     (hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fire_q <= 1'b0;
      else        fire_q <= hit;
   end
   assign wdt_rst = fire_q;

   always_comb begin
      ctrl_rd                              = '0;
      ctrl_rd[CTL_RUN]                     = run_sw;
      ctrl_rd[CTL_IDLE]                    = idle;
      ctrl_rd[CTL_SEL_LSB +: CTL_SEL_W]    = clk_sel;
      ctrl_rd[DW-1]                        = armed;
   end

   always_comb begin
      case (rd_addr)
         AW'(A_CTRL): rd_mux = ctrl_rd;
         AW'(A_CNTL): rd_mux = cnt_lo;
         AW'(A_CNTH): rd_mux = cnt_hi;
         AW'(A_MODE): rd_mux = mode_rd;
         AW'(A_OFFS): rd_mux = offset;
         AW'(A_KICK): rd_mux = cmp_hi;
         default:     rd_mux = '0;
      endcase
   end

   if (SYNC_READ) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_mux;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_mux;
   end
endmodule

// File: rtl/wdc_chk.sv
module wdc_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          armed,
   input logic          wdt_rst,
   input logic [DW-1:0] cnt_lo,
   input logic [DW-1:0] cnt_hi,
   input logic [DW-1:0] offset
);
   localparam int CW = 2 * DW;

   // R3: the pulse lasts one cycle
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);

   // R3: a pulse coincides with a freshly wrapped low byte
   a_r3_fire_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> (cnt_lo == '0) && $past(tick));

   // R6: while armed, the counter only moves on a tick
   a_r6_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !tick) |=> $stable({cnt_hi, cnt_lo}));

   // R7: while armed, every tick advances the counter
   a_r7_forced_run: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && tick) |=> ({cnt_hi, cnt_lo} == CW'($past({cnt_hi, cnt_lo}) + CW'(1))));

   // R5: offset is frozen while armed
   a_r5_offset_lock: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(offset));

   // R10: arm is still set while the pulse is out
   a_r10_armed_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> armed);

   // R11: no pulse follows a disarmed cycle
   a_r11_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !wdt_rst);
endmodule

bind cmp_watchdog wdc_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick),
   .armed   (armed),
   .wdt_rst (wdt_rst),
   .cnt_lo  (cnt_lo),
   .cnt_hi  (cnt_hi),
   .offset  (offset)
);

// File: tb/tb_cmp_watchdog.sv
module tb_cmp_watchdog;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       wdt_rst;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmp_watchdog dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .wdt_rst(wdt_rst)
   );

   // {op, addr, data, expect, req}; op 0 write, 1 read-check, 2 ticks(data)
   localparam int NV = 38;
   localparam logic [24:0] VT [NV] = '{
      {2'd1, 3'd0, 8'h00, 8'h80, 4'd1},  // R1 ctrl armed
      {2'd1, 3'd3, 8'h00, 8'h48, 4'd1},  // R1 mode forced
      {2'd1, 3'd5, 8'h00, 8'h00, 4'd1},
      {2'd0, 3'd1, 8'h55, 8'h00, 4'd6},  // R6 locked writes
      {2'd0, 3'd2, 8'h66, 8'h00, 4'd6},
      {2'd1, 3'd1, 8'h00, 8'h00, 4'd6},
      {2'd1, 3'd2, 8'h00, 8'h00, 4'd6},
      {2'd0, 3'd3, 8'h03, 8'h00, 4'd9},  // R9 mode locked
      {2'd1, 3'd3, 8'h00, 8'h48, 4'd9},
      {2'd0, 3'd0, 8'h9F, 8'h00, 4'd8},  // R8 fields frozen
      {2'd1, 3'd0, 8'h00, 8'h81, 4'd8},
      {2'd0, 3'd0, 8'h80, 8'h00, 4'd7},  // R7 run reads back
      {2'd1, 3'd0, 8'h00, 8'h80, 4'd7},
      {2'd0, 3'd4, 8'h22, 8'h00, 4'd5},  // R5 offset locked
      {2'd1, 3'd4, 8'h00, 8'h00, 4'd5},
      {2'd2, 3'd0, 8'h0A, 8'h00, 4'd7},  // R7 forced run
      {2'd1, 3'd1, 8'h00, 8'h0A, 4'd7},
      {2'd0, 3'd0, 8'h00, 8'h00, 4'd2},  // R2 disarm, run off
      {2'd2, 3'd0, 8'h05, 8'h00, 4'd2},
      {2'd1, 3'd1, 8'h00, 8'h0A, 4'd2},
      {2'd0, 3'd1, 8'hF0, 8'h00, 4'd2},
      {2'd0, 3'd2, 8'h12, 8'h00, 4'd2},
      {2'd1, 3'd1, 8'h00, 8'hF0, 4'd2},
      {2'd1, 3'd2, 8'h00, 8'h12, 4'd2},
      {2'd0, 3'd3, 8'h03, 8'h00, 4'd9},  // R9 disarmed mode
      {2'd1, 3'd3, 8'h00, 8'h03, 4'd9},
      {2'd0, 3'd0, 8'h1F, 8'h00, 4'd8},  // R8 disarmed fields
      {2'd1, 3'd0, 8'h00, 8'h1F, 4'd8},
      {2'd2, 3'd0, 8'h04, 8'h00, 4'd2},
      {2'd1, 3'd1, 8'h00, 8'hF4, 4'd2},
      {2'd0, 3'd4, 8'h03, 8'h00, 4'd5},  // R5 offset open
      {2'd1, 3'd4, 8'h00, 8'h03, 4'd5},
      {2'd0, 3'd5, 8'h77, 8'h00, 4'd4},  // R4 direct store
      {2'd1, 3'd5, 8'h00, 8'h77, 4'd4},
      {2'd0, 3'd0, 8'h80, 8'h00, 4'd4},
      {2'd1, 3'd3, 8'h00, 8'h48, 4'd9},
      {2'd0, 3'd5, 8'h00, 8'h00, 4'd4},  // R4 kick: 0x12 + 3
      {2'd1, 3'd5, 8'h00, 8'h15, 4'd4}
   };

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] e);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(req, int'(rd_data), int'(e));
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   // Ticks one at a time; returns the number of the first tick followed by a pulse.
   task automatic watch(input int n, output int first);
      first = 0;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         if (wdt_rst && first == 0) first = i;
      end
   endtask

   task automatic setup(input logic [7:0] off, input logic [7:0] lo, input logic [7:0] hi);
      wr(3'd0, 8'h00);
      wr(3'd4, off);
      wr(3'd1, lo);
      wr(3'd2, hi);
      wr(3'd0, 8'h80);
      wr(3'd5, 8'h00);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int first;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [24:0] w;
         w = VT[v];
         case (w[24:23])
            2'd0: wr(w[22:20], w[19:12]);
            2'd1: rd_check($sformatf("vec %0d R%0d", v, w[3:0]), w[22:20], w[11:4]);
            default: ticks(int'(w[19:12]));
         endcase
      end

      // R3: timeout 256*2 + (256-0x40) = 704 ticks
      setup(8'h02, 8'h40, 8'h05);
      rd_check("R4 kick 5+2", 3'd5, 8'h07);
      watch(704, first);
      check("R3 timeout tick", first, 704);
      @(negedge clk);
      check("R3 single-cycle pulse", int'(wdt_rst), 0);
      rd_check("R10 armed after pulse", 3'd0, 8'h80);

      // R3 offset 0 and R10 priority over a same-cycle disarm
      setup(8'h00, 8'hFE, 8'h20);
      watch(1, first);
      check("R3 no early pulse", first, 0);
      @(negedge clk);
      tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h00;
      @(negedge clk);
      tick = 1'b0; wr_en = 1'b0;
      check("R3 offset-0 pulse", int'(wdt_rst), 1);
      rd_check("R10 fire beats disarm", 3'd0, 8'h80);

      // R4 keep-alive: kick moves the deadline
      setup(8'h01, 8'h00, 8'h00);
      watch(400, first);
      check("R4 no pulse before kick", first, 0);
      wr(3'd5, 8'hAB);
      rd_check("R4 kick 1+1", 3'd5, 8'h02);
      watch(368, first);
      check("R4 pulse after rearm", first, 368);

      // R4 modulo-256 reload
      setup(8'h03, 8'h00, 8'hFE);
      rd_check("R4 wrap FE+3", 3'd5, 8'h01);

      // R11 disarmed with high byte equal to compare byte
      wr(3'd0, 8'h01);
      wr(3'd1, 8'hFE);
      wr(3'd2, 8'h01);
      watch(4, first);
      check("R11 no pulse disarmed", first, 0);
      rd_check("R2 counter ran", 3'd2, 8'h02);

      // R1 reset defaults and reset-time arming
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd_check("R1 ctrl", 3'd0, 8'h80);
      rd_check("R1 count low", 3'd1, 8'h00);
      rd_check("R1 offset", 3'd4, 8'h00);
      rd_check("R1 compare", 3'd5, 8'h00);
      watch(256, first);
      check("R1 default timeout", first, 256);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule